// File: doc/BRIEF.md
# System Control Port Register Bank

This block is a byte-wide register bank for a legacy ISA-style system controller that sits beside a processor. It decodes a 16-bit I/O port address and takes separate read and write strobes. Its stored state is small: a soft-reset request, a byte-order flag, a disk activity light, a four-bit system control field, an I/O map type bit and two scratch bytes. It also returns fixed board identification bytes, and two write-only ports each produce a one-cycle lock-toggle pulse for an external non-volatile memory.

A separate combinational path turns an offset inside the processor's I/O window into an ISA port address. The map type bit selects how this is done, and software can change that bit at any time. When the bit is clear the window is a plain 64 KB space. When it is set the window is a sparse 8 MB space in which each 4 KB page carries 32 ports.

Top module: `sys_port_bank`

## Requirements
- R1: After reset, every stored register reads as zero. The reset request, endian flag, disk light, both lock pulses and read data are all 0. The map type is contiguous.
- R2: A write to port 0x0092 sets the reset request from data bit 0 and the little-endian flag from data bit 1. A read of 0x0092 returns 0x00.
- R3: A write to port 0x0808 sets the disk light from data bit 0. The other data bits have no effect.
- R4: A write to port 0x081C stores data bits [3:0]. A read returns them in bits [3:0], with zeros above.
- R5: A write to port 0x0850 stores data bit 0 as the map type. A read returns that bit in bit 0, with zeros above.
- R6: With map type 0, the ISA port output equals bits [15:0] of the window offset, combinationally.
- R7: With map type 1, ISA port bits [4:0] equal offset bits [4:0] and ISA port bits [15:5] equal offset bits [22:12].
- R8: A write to 0x0810 pulses the lock-A output high for the one cycle after the write edge. A write to 0x0812 does the same for lock-B. Neither write stores data, so a read of 0x0810 still returns its identification byte.
- R9: Reads of the identification ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03. Writes to 0x0800, 0x0802 and 0x0803 change nothing.
- R10: A read of any port not listed in R2–R11 returns 0xFF. This includes 0x0814. A write to such a port, or to 0x0814, changes no state and no output.
- R11: Ports 0x0398 and 0x0399 are independent scratch bytes. Each reads back the last value written to it.
- R12: Read data is registered. It takes the value for the addressed port on the clock edge where the read strobe is sampled, and holds that value while no read is sampled. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | I/O port address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| win_off_i | input | 23 | Offset inside the processor I/O window |
| isa_port_o | output | 16 | Folded ISA port address |
| reset_req_o | output | 1 | Soft reset request |
| little_endian_o | output | 1 | Byte-order mode flag |
| disk_led_o | output | 1 | Disk activity light |
| lock_a_o | output | 1 | Lock-A toggle pulse |
| lock_b_o | output | 1 | Lock-B toggle pulse |

## Verification
Every stored control output and the lock pulses change on the same clock edge that samples a write strobe. Read data updates on the edge that samples a read strobe. The ISA port output changes in the same cycle as the offset or the map bit. Inputs are driven on falling edges. The behavioural model in the bench is updated at each rising edge, and all outputs are compared against it one nanosecond later, so each registered result is checked in the first half-cycle after the edge that makes it due. Directed checks sample on the following falling edge, and a change of the folded port address is checked within the same cycle.

// File: rtl/sys_port_pkg.sv
package sys_port_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  localparam logic [AW-1:0] P_SYSRST  = 16'h0092;
  localparam logic [AW-1:0] P_ID_CPU  = 16'h0800;
  localparam logic [AW-1:0] P_ID_FEAT = 16'h0802;
  localparam logic [AW-1:0] P_ID_STAT = 16'h0803;
  localparam logic [AW-1:0] P_LED     = 16'h0808;
  localparam logic [AW-1:0] P_ID_EQP  = 16'h080C;
  localparam logic [AW-1:0] P_LOCK_A  = 16'h0810;
  localparam logic [AW-1:0] P_LOCK_B  = 16'h0812;
  localparam logic [AW-1:0] P_KEY     = 16'h0818;
  localparam logic [AW-1:0] P_SYSCTL  = 16'h081C;
  localparam logic [AW-1:0] P_ID_L2   = 16'h0823;
  localparam logic [AW-1:0] P_MAP     = 16'h0850;
  localparam logic [AW-1:0] P_SCR     = 16'h0398;

  localparam logic [DW-1:0] RD_UNMAPPED = 8'hFF;

  typedef struct packed {
    logic sysrst;
    logic led;
    logic sysctl;
    logic map;
    logic lock_a;
    logic lock_b;
    logic scr;
  } sel_t;
endpackage

// File: rtl/sys_port_decode.sv
module sys_port_decode
  import sys_port_pkg::*;
#(
  parameter int SCR_N  = 2,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic [AW-1:0]     addr_i,
  output sel_t              sel_o,
  output logic [SCR_IW-1:0] scr_idx_o,
  output logic              id_hit_o,
  output logic [DW-1:0]     id_byte_o
);
  logic [AW-1:0] scr_diff;

  assign scr_diff = addr_i - P_SCR;

  always_comb begin
    sel_o        = '0;
    sel_o.sysrst = (addr_i == P_SYSRST);
    sel_o.led    = (addr_i == P_LED);
    sel_o.sysctl = (addr_i == P_SYSCTL);
    sel_o.map    = (addr_i == P_MAP);
    sel_o.lock_a = (addr_i == P_LOCK_A);
    sel_o.lock_b = (addr_i == P_LOCK_B);
    sel_o.scr    = (scr_diff < AW'(SCR_N));
  end

  assign scr_idx_o = scr_diff[SCR_IW-1:0];

  always_comb begin
    id_hit_o  = 1'b1;
    id_byte_o = '0;
    unique case (addr_i)
      P_ID_CPU:  id_byte_o = 8'hEF;
      P_ID_FEAT: id_byte_o = 8'hAD;
      P_ID_STAT: id_byte_o = 8'hE0;
      P_ID_EQP:  id_byte_o = 8'h3C;
      P_LOCK_A:  id_byte_o = 8'h39;
      P_KEY:     id_byte_o = 8'h00;
      P_ID_L2:   id_byte_o = 8'h03;
      default:   id_hit_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/sys_port_regs.sv
module sys_port_regs
  import sys_port_pkg::*;
#(
  parameter int SCR_N  = 2,
  parameter int CTL_W  = 4,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  input  sel_t              sel_i,
  input  logic [SCR_IW-1:0] scr_idx_i,
  input  logic              id_hit_i,
  input  logic [DW-1:0]     id_byte_i,
  output logic [DW-1:0]     rdata_o,
  output logic              reset_req_o,
  output logic              little_endian_o,
  output logic              disk_led_o,
  output logic              map_sparse_o,
  output logic              lock_a_o,
  output logic              lock_b_o
);
  logic [CTL_W-1:0] sysctl_q;
  logic [DW-1:0]    scr_q [SCR_N];
  logic [DW-1:0]    rd_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_req_o     <= 1'b0;
      little_endian_o <= 1'b0;
      disk_led_o      <= 1'b0;
      map_sparse_o    <= 1'b0;
      sysctl_q        <= '0;
    end else if (wr_i) begin
      if (sel_i.sysrst) begin
        reset_req_o     <= wdata_i[0];
        little_endian_o <= wdata_i[1];
      end
      if (sel_i.led)    disk_led_o   <= wdata_i[0];
      if (sel_i.sysctl) sysctl_q     <= wdata_i[CTL_W-1:0];
      if (sel_i.map)    map_sparse_o <= wdata_i[0];
    end
  end

  // lock strobes: one cycle high after the write edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_a_o <= 1'b0;
      lock_b_o <= 1'b0;
    end else begin
      lock_a_o <= wr_i & sel_i.lock_a;
      lock_b_o <= wr_i & sel_i.lock_b;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        scr_q[g] <= '0;
      else if (wr_i && sel_i.scr && (scr_idx_i == SCR_IW'(g)))
        scr_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_nxt = RD_UNMAPPED;
    if (sel_i.sysrst)      rd_nxt = '0;
    else if (id_hit_i)     rd_nxt = id_byte_i;
    else if (sel_i.sysctl) rd_nxt = DW'(sysctl_q);
    else if (sel_i.map)    rd_nxt = DW'(map_sparse_o);
    else if (sel_i.scr)    rd_nxt = scr_q[scr_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/sys_port_fold.sv
module sys_port_fold #(
  parameter int OFF_W   = 23,
  parameter int PW      = 16,
  parameter int KEEP_LO = 5,
  parameter int HI_LSB  = 12,
  localparam int HI_W   = PW - KEEP_LO
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             sparse_i,
  output logic [PW-1:0]    port_o
);
  logic [PW-1:0] dense, sparse;

  assign dense  = off_i[PW-1:0];
  // sparse map: 32 ports per 4 KB page
  assign sparse = {off_i[HI_LSB +: HI_W], off_i[KEEP_LO-1:0]};
  assign port_o = sparse_i ? sparse : dense;
endmodule

// File: rtl/sys_port_bank.sv
module sys_port_bank
  import sys_port_pkg::*;
#(
  parameter int SCR_N = 2,
  parameter int CTL_W = 4,
  parameter int OFF_W = 23,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [OFF_W-1:0] win_off_i,
  output logic [AW-1:0]    isa_port_o,
  output logic             reset_req_o,
  output logic             little_endian_o,
  output logic             disk_led_o,
  output logic             lock_a_o,
  output logic             lock_b_o
);
  sel_t              sel;
  logic [SCR_IW-1:0] scr_idx;
  logic              id_hit;
  logic [DW-1:0]     id_byte;
  logic              map_sparse;

  sys_port_decode #(.SCR_N(SCR_N)) u_dec (
    .addr_i    (addr_i),
    .sel_o     (sel),
    .scr_idx_o (scr_idx),
    .id_hit_o  (id_hit),
    .id_byte_o (id_byte)
  );

  sys_port_regs #(.SCR_N(SCR_N), .CTL_W(CTL_W)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_i            (wr_i),
    .rd_i            (rd_i),
    .wdata_i         (wdata_i),
    .sel_i           (sel),
    .scr_idx_i       (scr_idx),
    .id_hit_i        (id_hit),
    .id_byte_i       (id_byte),
    .rdata_o         (rdata_o),
    .reset_req_o     (reset_req_o),
    .little_endian_o (little_endian_o),
    .disk_led_o      (disk_led_o),
    .map_sparse_o    (map_sparse),
    .lock_a_o        (lock_a_o),
    .lock_b_o        (lock_b_o)
  );

  sys_port_fold #(.OFF_W(OFF_W), .PW(AW)) u_fold (
    .off_i    (win_off_i),
    .sparse_i (map_sparse),
    .port_o   (isa_port_o)
  );
endmodule

// File: rtl/sys_port_bank_chk.sv
module sys_port_bank_chk
  import sys_port_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          reset_req_o,
  input logic          little_endian_o,
  input logic          disk_led_o,
  input logic          lock_a_o,
  input logic          lock_b_o
);
  assert_rst_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && addr_i == P_SYSRST) |-> reset_req_o == $past(wdata_i[0]));

  assert_endian_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i && addr_i == P_SYSRST) |-> $stable(little_endian_o));

  assert_led_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i && addr_i == P_LED) |-> $stable(disk_led_o));

  assert_lock_a_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_a_o |-> $past(wr_i && addr_i == P_LOCK_A));

  assert_lock_b_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_b_o |-> $past(wr_i && addr_i == P_LOCK_B));

  assert_lock_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lock_a_o, lock_b_o}));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
endmodule

bind sys_port_bank sys_port_bank_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .addr_i          (addr_i),
  .wr_i            (wr_i),
  .rd_i            (rd_i),
  .wdata_i         (wdata_i),
  .rdata_o         (rdata_o),
  .reset_req_o     (reset_req_o),
  .little_endian_o (little_endian_o),
  .disk_led_o      (disk_led_o),
  .lock_a_o        (lock_a_o),
  .lock_b_o        (lock_b_o)
);

// File: tb/sys_port_bank_tb_top.sv
`timescale 1ns/1ps
module sys_port_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [22:0] win_off_i = '0;
  logic [15:0] isa_port_o;
  logic        reset_req_o, little_endian_o, disk_led_o, lock_a_o, lock_b_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sys_port_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .win_off_i(win_off_i),
    .isa_port_o(isa_port_o), .reset_req_o(reset_req_o),
    .little_endian_o(little_endian_o), .disk_led_o(disk_led_o),
    .lock_a_o(lock_a_o), .lock_b_o(lock_b_o)
  );

  // behavioural reference state
  int m_rdata, m_req, m_le, m_led, m_ctl, m_map, m_la, m_lb;
  int m_scr [2];

  function automatic int ref_read(int a);
    case (a)
      'h092: return 0;
      'h800: return 'hEF;
      'h802: return 'hAD;
      'h803: return 'hE0;
      'h80C: return 'h3C;
      'h810: return 'h39;
      'h818: return 0;
      'h823: return 3;
      'h81C: return m_ctl;
      'h850: return m_map;
      'h398: return m_scr[0];
      'h399: return m_scr[1];
      default: return 'hFF;
    endcase
  endfunction

  function automatic int ref_fold(int off, int sparse);
    if (sparse != 0) return (off % 32) + ((off / 4096) % 2048) * 32;
    return off % 65536;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rdata = 0; m_req = 0; m_le = 0; m_led = 0; m_ctl = 0; m_map = 0;
      m_la = 0; m_lb = 0; m_scr[0] = 0; m_scr[1] = 0;
    end else begin
      int a, d;
      a = int'(addr_i);
      d = int'(wdata_i);
      if (rd_i) m_rdata = ref_read(a);
      m_la = (wr_i && a == 'h810) ? 1 : 0;
      m_lb = (wr_i && a == 'h812) ? 1 : 0;
      if (wr_i) begin
        case (a)
          'h092: begin m_req = d % 2; m_le = (d / 2) % 2; end
          'h808: m_led = d % 2;
          'h81C: m_ctl = d % 16;
          'h850: m_map = d % 2;
          'h398: m_scr[0] = d;
          'h399: m_scr[1] = d;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk_i);
    #1;
    if (rst_ni && !done) begin
      chk("R12 rdata", int'(rdata_o), m_rdata);
      chk("R2 reset_req", int'(reset_req_o), m_req);
      chk("R2 endian", int'(little_endian_o), m_le);
      chk("R3 led", int'(disk_led_o), m_led);
      chk("R8 lock_a", int'(lock_a_o), m_la);
      chk("R8 lock_b", int'(lock_b_o), m_lb);
      chk(m_map != 0 ? "R7 fold" : "R6 fold", int'(isa_port_o),
          ref_fold(int'(win_off_i), m_map));
    end
  end

  task automatic do_wr(int a, int d);
    @(negedge clk_i);
    addr_i = 16'(a); wdata_i = 8'(d); wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(int a, int exp, string req);
    @(negedge clk_i);
    addr_i = 16'(a); rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk(req, int'(rdata_o), exp);
  endtask

  int ports [19] = '{'h092, 'h800, 'h802, 'h803, 'h808, 'h80C, 'h810, 'h812,
                     'h814, 'h818, 'h81C, 'h823, 'h850, 'h398, 'h399, 'h801,
                     'h851, 'h39A, 'h1234};

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #9;
    // R1: reset state
    chk("R1 rdata", int'(rdata_o), 0);
    chk("R1 reset_req", int'(reset_req_o), 0);
    chk("R1 endian", int'(little_endian_o), 0);
    chk("R1 led", int'(disk_led_o), 0);
    chk("R1 locks", int'({lock_a_o, lock_b_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_rd('h81C, 0, "R1 sysctl");
    do_rd('h850, 0, "R1 map");
    do_rd('h398, 0, "R1 scratch");
    // R2
    do_wr('h092, 'h03);
    chk("R2 req set", int'(reset_req_o), 1);
    chk("R2 le set", int'(little_endian_o), 1);
    do_rd('h092, 0, "R2 read");
    do_wr('h092, 'h02);
    chk("R2 req clr", int'(reset_req_o), 0);
    // R3
    do_wr('h808, 'hFE);
    chk("R3 led ignore", int'(disk_led_o), 0);
    do_wr('h808, 'h01);
    chk("R3 led on", int'(disk_led_o), 1);
    // R4, R5
    do_wr('h81C, 'hA7);
    do_rd('h81C, 'h07, "R4 nibble");
    @(negedge clk_i);
    win_off_i = 23'h2AB015;
    #1 chk("R6 dense", int'(isa_port_o), 'hB015);
    do_wr('h850, 'hFF);
    chk("R7 sparse", int'(isa_port_o), 'h5575);
    do_rd('h850, 1, "R5 map");
    do_wr('h850, 'h00);
    chk("R6 back", int'(isa_port_o), 'hB015);
    // R8
    do_wr('h810, 'h55);
    do_rd('h810, 'h39, "R8 no store");
    do_wr('h812, 'h00);
    // R9
    do_wr('h800, 0);
    do_wr('h802, 0);
    do_wr('h803, 0);
    do_rd('h800, 'hEF, "R9 cpu");
    do_rd('h802, 'hAD, "R9 feat");
    do_rd('h803, 'hE0, "R9 stat");
    do_rd('h80C, 'h3C, "R9 eqp");
    do_rd('h818, 'h00, "R9 key");
    do_rd('h823, 'h03, "R9 l2");
    // R11
    do_wr('h398, 'h5A);
    do_wr('h399, 'hC3);
    do_rd('h398, 'h5A, "R11 scr0");
    do_rd('h399, 'hC3, "R11 scr1");
    // R10
    do_rd('h801, 'hFF, "R10 hole");
    do_rd('h814, 'hFF, "R10 inval");
    do_wr('h814, 'hFF);
    do_wr('h1234, 'hFF);
    do_wr('h851, 'hFF);
    chk("R10 led kept", int'(disk_led_o), 1);
    chk("R10 req kept", int'(reset_req_o), 0);
    do_rd('h81C, 'h07, "R10 sysctl kept");
    do_rd('h850, 0, "R10 map kept");
    do_rd('h399, 'hC3, "R10 scr kept");
    // R12: read alongside write returns the prior value
    @(negedge clk_i);
    addr_i = 16'h0398; wdata_i = 8'h11; wr_i = 1'b1; rd_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    chk("R12 old value", int'(rdata_o), 'h5A);
    // mixed traffic, compared every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      addr_i    = 16'(ports[$urandom_range(0, 18)]);
      wdata_i   = 8'($urandom);
      wr_i      = ($urandom_range(0, 2) == 0);
      rd_i      = ($urandom_range(0, 1) == 0);
      win_off_i = 23'($urandom);
    end
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule